// File: doc/BRIEF.md
# Quadrature Sample Combiner and Scaler

This block turns a stream of 32-bit counter snapshots into 8-bit I/Q samples. The snapshots arrive as alternating positive and negative readings. Each pair is reduced to its difference. The change of that difference since the previous pair is then steered into the I or Q accumulator, following a fixed four-step rotation. Every eight input words close one complex sample.

Each closed sample is scaled by a gain and normalised by a full-scale value derived from the system clock and the configured sample rate. A fixed fraction of full scale is subtracted, the result is saturated to a signed byte and shifted into offset-binary form. The block emits two bytes per sample, I first. A marker flags the last byte of every block of samples.

Input and output are valid/ready streams. A word transfers on an input clock edge with `in_valid` and `in_ready` both high. A byte transfers on an output edge with `out_valid` and `out_ready` both high. Once raised, `out_valid` stays high with its byte and marker unchanged until the byte is taken. While a sample is still being computed or drained, the block withholds `in_ready` only for the eighth word of the next sample. Nothing is ever dropped.

Top module: `iq_combiner`

## Requirements
- R1: For each (pos, neg) word pair, taken in that order, the block forms v = pos − neg in 32-bit wrapping arithmetic. The contribution is v − prev, after which prev becomes v. prev persists across sample boundaries and is zero after reset.
- R2: The four pair contributions of a sample are applied in this order: added to I, added to Q, subtracted from I, subtracted from Q. Both accumulators start each sample at zero, in 32-bit wrapping arithmetic.
- R3: The full-scale value is M = floor((CLK_HZ/2) / (2 × rate)). When rate is zero or M comes out zero, M = 1 is used instead.
- R4: Each channel value x gives q = (x × gain − floor(M × 181 / 256)) / M. The product is computed in 64-bit signed arithmetic and the division truncates toward zero.
- R5: q is clamped to −128..127 and emitted as the unsigned byte q + 128. For example, 127 gives 0xFF and −128 gives 0x00.
- R6: Each sample yields exactly two output bytes, the I byte first and then the Q byte. After reset `out_valid` is low and `in_ready` is high.
- R7: `out_last` is high on the Q byte of every PAIRS_PER_BLOCK-th sample counted from reset (default 32, so every 64th byte). It is low on all other bytes.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_last` stay unchanged. No output byte is lost or duplicated.
- R9: Words 1 to 7 of a sample are accepted at any time. The eighth word is refused (`in_ready` low) until the previous sample's Q byte has been taken.
- R10: The `gain` and `rate` values used for a sample are those present in the cycle its eighth word is accepted. Changes at any other time do not affect that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept the offered word |
| in_word | input | 32 | Counter snapshot, alternately pos and neg |
| gain | input | 16 | Unsigned gain multiplier |
| rate | input | 32 | Sample rate in Hz used for full scale |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_byte | output | 8 | Offset-binary I or Q byte |
| out_last | output | 1 | Last byte of a block |

## Verification
A sample's I byte becomes valid 198 clock edges after its eighth word is accepted. This delay is made up of three 64-step divisions plus the handoff edges. The Q byte is ready on the edge after the I byte is taken. `in_ready` for the following eighth word returns on the edge that takes the Q byte.

Because the delay is long and fixed, the bench does not count cycles to find outputs. It queues the expected bytes when it hands over each eighth word, and compares bytes only on cycles where `out_valid` and `out_ready` are both high, sampled at the falling edge.

The check on the refused eighth word is timed from the acceptance edge of the seventh word. At that point the previous sample is still inside its first division, so `in_ready` must be low.

// File: rtl/iqc_pkg.sv
package iqc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FULLSCALE,
    ST_DIV_I,
    ST_DIV_Q,
    ST_EMIT_I,
    ST_EMIT_Q
  } scl_state_e;

  localparam int unsigned OFFS_NUM   = 181;
  localparam int unsigned OFFS_SHIFT = 8;

  function automatic logic [7:0] sat_offset_byte(input logic signed [63:0] q);
    logic [7:0] b;
    if (q > 64'sd127)       b = 8'hFF;
    else if (q < -64'sd128) b = 8'h00;
    else                    b = q[7:0] ^ 8'h80;
    return b;
  endfunction

endpackage

// File: rtl/iqc_accum.sv
module iqc_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [W-1:0] word,
  output logic         on_last,
  output logic [W-1:0] sum_i_nxt,
  output logic [W-1:0] sum_q_nxt
);
  logic [2:0]   phase;
  logic [W-1:0] pos_r, prev_r, acc_i, acc_q;
  logic [W-1:0] diff, contrib;

  assign on_last = (phase == 3'd7);
  assign diff    = pos_r - word;
  assign contrib = diff - prev_r;

  always_comb begin
    sum_i_nxt = acc_i;
    sum_q_nxt = acc_q;
    if (phase[0]) begin
      unique case (phase[2:1])
        2'd0: sum_i_nxt = acc_i + contrib;
        2'd1: sum_q_nxt = acc_q + contrib;
        2'd2: sum_i_nxt = acc_i - contrib;
        default: sum_q_nxt = acc_q - contrib;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      pos_r  <= '0;
      prev_r <= '0;
      acc_i  <= '0;
      acc_q  <= '0;
    end else if (fire) begin
      phase <= phase + 3'd1;
      if (!phase[0]) pos_r <= word;
      else           prev_r <= diff;
      if (on_last) begin
        acc_i <= '0;
        acc_q <= '0;
      end else begin
        acc_i <= sum_i_nxt;
        acc_q <= sum_q_nxt;
      end
    end
  end
endmodule

// File: rtl/iqc_div.sv
module iqc_div #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quot
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem, sh;
  logic [W-1:0]  q, mag;
  logic [CW-1:0] cnt;
  logic          busy, neg;

  assign mag  = num[W-1] ? (~num + 1'b1) : num;
  assign sh   = {rem[W-1:0], q[W-1]};
  assign quot = neg ? (~q + 1'b1) : q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      q    <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      neg  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= '0;
        q    <= mag;
        cnt  <= CW'(W);
        busy <= 1'b1;
        neg  <= num[W-1];
      end else if (busy) begin
        if (sh >= {1'b0, den}) begin
          rem <= sh - {1'b0, den};
          q   <= {q[W-2:0], 1'b1};
        end else begin
          rem <= sh;
          q   <= {q[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/iqc_scale.sv
module iqc_scale
  import iqc_pkg::*;
#(
  parameter longint unsigned CLK_HZ          = 300_000_000,
  parameter int              W               = 32,
  parameter int              GAIN_W          = 16,
  parameter int              RATE_W          = 32,
  parameter int              PAIRS_PER_BLOCK = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [W-1:0]      sum_i,
  input  logic [W-1:0]      sum_q,
  input  logic [GAIN_W-1:0] gain,
  input  logic [RATE_W-1:0] rate,
  output logic              idle,
  output logic              sel_q,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic              out_last
);
  localparam int DW = 64;
  localparam int BW = (PAIRS_PER_BLOCK > 1) ? $clog2(PAIRS_PER_BLOCK) : 1;
  localparam logic [DW-1:0] HALF_CLK = DW'(CLK_HZ / 2);

  scl_state_e        st;
  logic [W-1:0]      si_r, sq_r;
  logic [GAIN_W-1:0] gain_r;
  logic [RATE_W-1:0] rate_r;
  logic [DW-1:0]     max_r, offs_r;
  logic [7:0]        byte_i, byte_q;
  logic [BW-1:0]     pair_cnt;
  logic              div_start, div_done;
  logic [DW-1:0]     div_num, div_den, div_q;
  logic [DW-1:0]     max_eff, offs_eff, max_x181;
  logic signed [DW-1:0] prod_i, prod_q, g64;

  iqc_div #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num(div_num), .den(div_den), .done(div_done), .quot(div_q)
  );

  assign max_eff  = (rate_r == '0 || div_q == '0) ? DW'(1) : div_q;
  assign max_x181 = max_eff * DW'(OFFS_NUM);
  assign offs_eff = max_x181 >> OFFS_SHIFT;
  assign g64      = $signed({{(DW-GAIN_W){1'b0}}, gain_r});
  assign prod_i   = $signed({{(DW-W){si_r[W-1]}}, si_r}) * g64;
  assign prod_q   = $signed({{(DW-W){sq_r[W-1]}}, sq_r}) * g64;

  assign idle      = (st == ST_IDLE);
  assign sel_q     = (st == ST_EMIT_Q);
  assign out_valid = (st == ST_EMIT_I) || (st == ST_EMIT_Q);
  assign out_byte  = sel_q ? byte_q : byte_i;
  assign out_last  = sel_q && (pair_cnt == BW'(PAIRS_PER_BLOCK - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      si_r      <= '0;
      sq_r      <= '0;
      gain_r    <= '0;
      rate_r    <= '0;
      max_r     <= DW'(1);
      offs_r    <= '0;
      byte_i    <= 8'h80;
      byte_q    <= 8'h80;
      pair_cnt  <= '0;
      div_start <= 1'b0;
      div_num   <= '0;
      div_den   <= DW'(1);
    end else begin
      div_start <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          si_r      <= sum_i;
          sq_r      <= sum_q;
          gain_r    <= gain;
          rate_r    <= rate;
          div_num   <= HALF_CLK;
          div_den   <= {{(DW-RATE_W-1){1'b0}}, rate, 1'b0};
          div_start <= 1'b1;
          st        <= ST_FULLSCALE;
        end
        ST_FULLSCALE: if (div_done) begin
          max_r     <= max_eff;
          offs_r    <= offs_eff;
          div_num   <= prod_i - offs_eff;
          div_den   <= max_eff;
          div_start <= 1'b1;
          st        <= ST_DIV_I;
        end
        ST_DIV_I: if (div_done) begin
          byte_i    <= sat_offset_byte(div_q);
          div_num   <= prod_q - offs_r;
          div_den   <= max_r;
          div_start <= 1'b1;
          st        <= ST_DIV_Q;
        end
        ST_DIV_Q: if (div_done) begin
          byte_q <= sat_offset_byte(div_q);
          st     <= ST_EMIT_I;
        end
        ST_EMIT_I: if (out_ready) st <= ST_EMIT_Q;
        ST_EMIT_Q: if (out_ready) begin
          pair_cnt <= (pair_cnt == BW'(PAIRS_PER_BLOCK - 1)) ? '0 : pair_cnt + 1'b1;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iq_combiner.sv
module iq_combiner #(
  parameter longint unsigned CLK_HZ          = 300_000_000,
  parameter int              W               = 32,
  parameter int              GAIN_W          = 16,
  parameter int              RATE_W          = 32,
  parameter int              PAIRS_PER_BLOCK = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_word,
  input  logic [GAIN_W-1:0] gain,
  input  logic [RATE_W-1:0] rate,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic              out_last
);
  logic         acc_last, in_fire, scl_idle, scl_sel_q;
  logic [W-1:0] sum_i_nxt, sum_q_nxt;

  assign in_ready = scl_idle || !acc_last;
  assign in_fire  = in_valid && in_ready;

  iqc_accum #(.W(W)) u_acc (
    .clk(clk), .rst_n(rst_n), .fire(in_fire), .word(in_word),
    .on_last(acc_last), .sum_i_nxt(sum_i_nxt), .sum_q_nxt(sum_q_nxt)
  );

  iqc_scale #(
    .CLK_HZ(CLK_HZ), .W(W), .GAIN_W(GAIN_W), .RATE_W(RATE_W),
    .PAIRS_PER_BLOCK(PAIRS_PER_BLOCK)
  ) u_scl (
    .clk(clk), .rst_n(rst_n), .start(in_fire && acc_last),
    .sum_i(sum_i_nxt), .sum_q(sum_q_nxt), .gain(gain), .rate(rate),
    .idle(scl_idle), .sel_q(scl_sel_q),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_last(out_last)
  );
endmodule

// File: rtl/iqc_chk.sv
module iqc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_last,
  input logic       sel_q,
  input logic       scl_idle,
  input logic [7:0] out_byte
);
  a_r8_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_last));

  a_r6_q_follows_i: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !sel_q |=> out_valid && sel_q);

  a_r6_gap_after_q: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && sel_q |=> !out_valid);

  a_r7_last_on_q_only: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid && sel_q);

  a_r9_refuse_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !scl_idle);
endmodule

bind iq_combiner iqc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_last(out_last), .sel_q(scl_sel_q),
  .scl_idle(scl_idle), .out_byte(out_byte)
);

// File: tb/sim_iq_combiner.sv
module sim_iq_combiner;
  localparam longint CLK_HZ = 300_000_000;
  localparam int     BLOCK  = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [15:0] gain = '0;
  logic [31:0] rate = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_byte;
  logic        out_last;

  always #2.5 clk = ~clk;

  iq_combiner u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .gain(gain), .rate(rate), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .out_last(out_last)
  );

  int    checks = 0, fails = 0, cyc = 0;
  string tag = "R6";
  int    rdy_mode = 0;
  int unsigned lcg = 32'h1234_5678, rlcg = 32'h0BAD_F00D;
  byte unsigned exp_b[$];
  bit           exp_l[$];
  int  m_prev = 0;
  int  m_samples = 0;

  function automatic int unsigned rnd();
    lcg = lcg * 32'h41c64e6d + 32'd12345;
    return lcg;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Independent arithmetic model of R1..R5 plus R7 block marking.
  task automatic model(input int unsigned w[8], input int unsigned g, input int unsigned r);
    int si, sq, v, c;
    longint m, offs, qi, qq;
    si = 0; sq = 0;
    for (int k = 0; k < 4; k++) begin
      v = int'(w[2*k]) - int'(w[2*k+1]);
      c = v - m_prev;
      m_prev = v;
      case (k)
        0: si += c;
        1: sq += c;
        2: si -= c;
        default: sq -= c;
      endcase
    end
    if (r == 0) m = 1;
    else begin
      m = (CLK_HZ / 2) / (2 * longint'(r));
      if (m == 0) m = 1;
    end
    offs = (m * 181) / 256;
    qi = (longint'(si) * longint'(g) - offs) / m;
    qq = (longint'(sq) * longint'(g) - offs) / m;
    if (qi > 127) qi = 127; else if (qi < -128) qi = -128;
    if (qq > 127) qq = 127; else if (qq < -128) qq = -128;
    exp_b.push_back(byte'(qi + 128)); exp_l.push_back(1'b0);
    exp_b.push_back(byte'(qq + 128)); exp_l.push_back((m_samples % BLOCK) == BLOCK - 1);
    m_samples++;
  endtask

  task automatic push(input logic [31:0] w);
    bit ok;
    in_word  = w;
    in_valid = 1'b1;
    forever begin
      ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 1'b0;
  endtask

  // One phase: n samples; word deltas masked; swap selects R10 config switching.
  task automatic run_phase(input string t, input int unsigned g, input int unsigned r,
                           input int unsigned mask, input int mode, input bit swap,
                           input bit chk_r9);
    int unsigned w[8];
    int unsigned cp, cn;
    tag = t; rdy_mode = mode;
    cp = rnd(); cn = rnd();
    for (int s = 0; s < BLOCK; s++) begin
      for (int k = 0; k < 8; k++) begin
        if (k[0] == 1'b0) begin cp += rnd() & mask; w[k] = cp; end
        else              begin cn += rnd() & mask; w[k] = cn; end
      end
      for (int k = 0; k < 8; k++) begin
        if (swap) begin
          gain = (k == 7) ? 16'(g) : 16'(g ^ 16'h5A5A);
          rate = (k == 7) ? r : r + 32'd77777;
        end else begin
          gain = 16'(g); rate = r;
        end
        if (k == 7) model(w, g, r);
        if (!swap && !chk_r9 && (rnd() & 3) == 0) @(negedge clk);
        push(w[k]);
        if (swap) begin gain = 16'(g ^ 16'h0F0F); rate = r + 32'd12345; end
        // R9: eighth word refused while the previous sample is still computing.
        if (chk_r9 && s > 0 && k == 6) check("R9 eighth word held", in_ready, 0);
      end
    end
    while (exp_b.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Output monitor: sets ready then compares on handshakes (R6, R7, R8).
  always @(negedge clk) begin
    if (rst_n) begin
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: begin rlcg = rlcg * 32'h41c64e6d + 32'd12345; out_ready = rlcg[20]; end
        default: begin rlcg = rlcg * 32'h41c64e6d + 32'd12345; out_ready = (rlcg[22:20] == 3'd0); end
      endcase
      if (out_valid && out_ready) begin
        if (exp_b.size() == 0) check({tag, " R8 unexpected byte"}, out_byte, -1);
        else begin
          check({tag, " R6 byte"}, out_byte, exp_b.pop_front());
          check("R7 last marker", out_last, exp_l.pop_front());
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 195000) begin
      check("watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset out_valid low", out_valid, 0);
    check("R6 reset in_ready high", in_ready, 1);
    run_phase("R1 R2 R4 small", 127, 100000, 32'hF, 0, 0, 0);
    run_phase("R2 R8 random ready", 300, 50000, 32'h3F, 1, 0, 0);
    run_phase("R5 saturation", 16'hFFFF, 100000, 32'hFFFF, 0, 0, 0);
    run_phase("R3 zero rate", 1, 0, 32'h3, 1, 0, 0);
    run_phase("R3 fullscale floor zero", 2, 32'hFFFF_FFFF, 32'h1F, 0, 0, 0);
    run_phase("R4 wide words", 16'hFFFF, 1, 32'hFFFF_FFFF, 0, 0, 0);
    run_phase("R10 config sampled", 900, 200000, 32'hFF, 1, 1, 0);
    run_phase("R9 R8 sparse ready", 0, 200000, 32'h7, 2, 0, 1);
    check("R7 all bytes drained", exp_b.size(), 0);
    summary();
  end
endmodule